// File: doc/BRIEF.md
# Readout Tag Phasing Checker

This block checks that every front-end layer on a group of readout cables reports the event tag it should. An event opens when an event summary word hands over the expected tag. Layer reports then arrive as a stream of (cable, layer, tag) beats in any order. Each cable has nine layers, numbered 0 to 8. The check has two levels. Layer 0 of a cable is compared with the summary tag, and a mismatch raises that cable's overall phasing flag. Layers 1 to 8 are compared with their own cable's layer 0, not with the summary tag, and each mismatch raises that layer's phasing flag.

The result is published when every layer of every cable has reported, or earlier when an end-of-event strobe arrives. A layer that has not reported by the strobe raises a missing flag and takes no part in any tag comparison. The result is registered, marked with a one-cycle done pulse and held until the next event opens. A status word gives a per-event summary of the three flag kinds and a copy of that summary that stays set from reset onward.

Both inputs use valid/ready back-pressure. A summary word is taken only while no event is open (`sum_ready` high). Layer beats are taken only while an event is open and still collecting (`in_ready` high). `in_ready` drops once all layers have reported, and it is low in any cycle where `eoe` is high, so a beat offered in that cycle is not taken. A source must hold its beat until it sees ready.

Top module: `tag_phase_check`

## Requirements
- R1: After reset `sum_ready` is 1, `in_ready` and `done` are 0, and every flag and status bit is 0.
- R2: `sum_ready` is high only while no event is open. Accepting a summary word clears every per-event flag and status bits [2:0], and bits [5:3] keep their value. `in_ready` is then high while the event collects. It is low while idle and in any cycle where `eoe` is high.
- R3: `ovr_err[c]` is set when layer 0 of cable c reported a tag that is not exactly equal to the summary tag. The comparison is plain equality, with no modulo allowance.
- R4: `lyr_err[c*9+l]` (l = 1..8) is set when layer l and layer 0 of cable c both reported and their tags differ. Bit `c*9+0` is always 0.
- R5: A cable whose nine layers all carry the same wrong tag, such as N+1, raises only `ovr_err` for that cable and no `lyr_err` bit.
- R6: A cable whose layer 0 carries N-1 while layers 1 to 8 carry N+1 raises `ovr_err` for that cable and all eight of its `lyr_err` bits.
- R7: When the beat that completes the last unreported layer is accepted at clock edge k, results are registered at edge k+1 and `done` is high for exactly that one cycle.
- R8: `eoe` sampled high while collecting publishes results at that edge, with `done` high for the following cycle. Each unreported layer sets `miss_err[c*9+l]`. An unreported layer 0 suppresses both `ovr_err[c]` and that cable's `lyr_err` bits.
- R9: A beat with a layer index of 9 or more is accepted and has no effect. A second beat for the same cable and layer replaces the earlier tag.
- R10: Status bits [0], [1] and [2] are the OR of `ovr_err`, `lyr_err` and `miss_err` for the current event. Bits [3], [4] and [5] are the same three summaries ORed over every event since reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sum_valid | input | 1 | Summary word offered |
| sum_ready | output | 1 | Summary word can be taken (no event open) |
| sum_tag | input | TAG_W | Expected event tag |
| in_valid | input | 1 | Layer beat offered |
| in_ready | output | 1 | Layer beat can be taken |
| in_cable | input | CAB_W | Cable index of the beat |
| in_layer | input | LAY_W | Layer index of the beat |
| in_tag | input | TAG_W | Tag reported by that layer |
| eoe | input | 1 | End-of-event strobe |
| done | output | 1 | One-cycle pulse: results are valid |
| ovr_err | output | N_CABLE | Per-cable overall phasing flag |
| lyr_err | output | N_CABLE*9 | Per-layer phasing flag, bit c*9+l |
| miss_err | output | N_CABLE*9 | Per-layer missing flag, bit c*9+l |
| status | output | 6 | [2:0] current event summary, [5:3] sticky summary |

## Verification
When a beat completes the last unreported layer, `done` and the flags change one clock after the edge that accepted that beat. When `eoe` is sampled, they change at that same edge. Accepting a summary word clears the flags at the edge that takes it. The bench drives inputs on falling edges and samples on falling edges. After the completing beat it checks that `done` is still low at the next falling edge and high at the one after that. After `eoe` it checks `done` at the first falling edge. Every expected flag pattern is rebuilt from the tags the bench itself sent.

// File: rtl/tpc_pkg.sv
package tpc_pkg;
  typedef enum logic {
    ST_IDLE    = 1'b0,
    ST_COLLECT = 1'b1
  } tpc_state_e;

  localparam int STATUS_W = 6;
endpackage

// File: rtl/tpc_ctrl.sv
module tpc_ctrl
  import tpc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sum_valid,
  input  logic eoe,
  input  logic all_seen,
  output logic sum_ready,
  output logic in_ready,
  output logic open_evt,
  output logic finish
);
  tpc_state_e state_q;

  assign sum_ready = (state_q == ST_IDLE);
  assign open_evt  = sum_ready & sum_valid;
  assign finish    = (state_q == ST_COLLECT) & (all_seen | eoe);
  assign in_ready  = (state_q == ST_COLLECT) & ~eoe & ~all_seen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else if (open_evt) begin
      state_q <= ST_COLLECT;
    end else if (finish) begin
      state_q <= ST_IDLE;
    end
  end

  // R2: the two input channels are never open together
  a_r2_ready_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(sum_ready && in_ready));

  // R2: an opened event leaves idle on the next cycle
  a_r2_open_leaves_idle: assert property (@(posedge clk) disable iff (!rst_n)
    open_evt |=> !sum_ready);
endmodule

// File: rtl/tpc_tag_store.sv
module tpc_tag_store #(
  parameter int N_CABLE = 4,
  parameter int N_LAYER = 9,
  parameter int TAG_W   = 3,
  parameter int CAB_W   = 2,
  parameter int LAY_W   = 4
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           clear,
  input  logic                           wr_en,
  input  logic [CAB_W-1:0]               wr_cable,
  input  logic [LAY_W-1:0]               wr_layer,
  input  logic [TAG_W-1:0]               wr_tag,
  output logic [N_CABLE*N_LAYER*TAG_W-1:0] tags,
  output logic [N_CABLE*N_LAYER-1:0]     seen
);
  localparam int N_SLOT = N_CABLE * N_LAYER;

  for (genvar c = 0; c < N_CABLE; c++) begin : g_cab
    for (genvar l = 0; l < N_LAYER; l++) begin : g_lay
      localparam int IDX = c * N_LAYER + l;
      logic hit;
      assign hit = wr_en && (wr_cable == CAB_W'(c)) && (wr_layer == LAY_W'(l));

      always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
          seen[IDX] <= 1'b0;
          tags[IDX*TAG_W +: TAG_W] <= '0;
        end else if (hit) begin
          seen[IDX] <= 1'b1;
          tags[IDX*TAG_W +: TAG_W] <= wr_tag;
        end
      end
    end
  end

  // R9: a layer index beyond the last layer leaves the presence map untouched
  a_r9_range_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !clear && (int'(wr_layer) >= N_LAYER)) |=> $stable(seen));

  // R2: clearing empties the presence map
  a_r2_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> ($countones(seen) == 0));

  initial begin
    assert (N_SLOT > 0);
  end
endmodule

// File: rtl/tpc_cable_cmp.sv
module tpc_cable_cmp #(
  parameter int N_LAYER = 9,
  parameter int TAG_W   = 3
) (
  input  logic [TAG_W-1:0]         sum_tag,
  input  logic [N_LAYER*TAG_W-1:0] tags,
  input  logic [N_LAYER-1:0]       seen,
  output logic                     ovr,
  output logic [N_LAYER-1:0]       lyr,
  output logic [N_LAYER-1:0]       miss
);
  logic [TAG_W-1:0] ref_tag;
  assign ref_tag = tags[TAG_W-1:0];

  // first level: layer 0 against the event summary
  assign ovr = seen[0] && (ref_tag != sum_tag);
  assign miss = ~seen;
  assign lyr[0] = 1'b0;

  // second level: every other layer against layer 0 of its own cable
  for (genvar l = 1; l < N_LAYER; l++) begin : g_lay
    assign lyr[l] = seen[0] && seen[l] && (tags[l*TAG_W +: TAG_W] != ref_tag);
  end
endmodule

// File: rtl/tag_phase_check.sv
module tag_phase_check
  import tpc_pkg::*;
#(
  parameter int N_CABLE = 4,
  parameter int TAG_W   = 3,
  parameter int N_LAYER = 9,
  parameter int CAB_W   = (N_CABLE > 1) ? $clog2(N_CABLE) : 1,
  parameter int LAY_W   = $clog2(N_LAYER + 1)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       sum_valid,
  output logic                       sum_ready,
  input  logic [TAG_W-1:0]           sum_tag,
  input  logic                       in_valid,
  output logic                       in_ready,
  input  logic [CAB_W-1:0]           in_cable,
  input  logic [LAY_W-1:0]           in_layer,
  input  logic [TAG_W-1:0]           in_tag,
  input  logic                       eoe,
  output logic                       done,
  output logic [N_CABLE-1:0]         ovr_err,
  output logic [N_CABLE*N_LAYER-1:0] lyr_err,
  output logic [N_CABLE*N_LAYER-1:0] miss_err,
  output logic [STATUS_W-1:0]        status
);
  localparam int N_SLOT = N_CABLE * N_LAYER;

  logic                      open_evt, finish, all_seen;
  logic [TAG_W-1:0]          sum_tag_q;
  logic [N_SLOT*TAG_W-1:0]   tags;
  logic [N_SLOT-1:0]         seen;
  logic [N_CABLE-1:0]        ovr_d;
  logic [N_SLOT-1:0]         lyr_d, miss_d;
  logic [2:0]                cur_q, sticky_q, cur_d;
  logic                      done_q;

  assign all_seen = &seen;

  tpc_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .sum_valid (sum_valid),
    .eoe       (eoe),
    .all_seen  (all_seen),
    .sum_ready (sum_ready),
    .in_ready  (in_ready),
    .open_evt  (open_evt),
    .finish    (finish)
  );

  tpc_tag_store #(
    .N_CABLE (N_CABLE),
    .N_LAYER (N_LAYER),
    .TAG_W   (TAG_W),
    .CAB_W   (CAB_W),
    .LAY_W   (LAY_W)
  ) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (open_evt),
    .wr_en    (in_valid & in_ready),
    .wr_cable (in_cable),
    .wr_layer (in_layer),
    .wr_tag   (in_tag),
    .tags     (tags),
    .seen     (seen)
  );

  for (genvar c = 0; c < N_CABLE; c++) begin : g_cab
    tpc_cable_cmp #(
      .N_LAYER (N_LAYER),
      .TAG_W   (TAG_W)
    ) u_cmp (
      .sum_tag (sum_tag_q),
      .tags    (tags[c*N_LAYER*TAG_W +: N_LAYER*TAG_W]),
      .seen    (seen[c*N_LAYER +: N_LAYER]),
      .ovr     (ovr_d[c]),
      .lyr     (lyr_d[c*N_LAYER +: N_LAYER]),
      .miss    (miss_d[c*N_LAYER +: N_LAYER])
    );

    // R4: the layer-0 position never carries a per-layer flag
    a_r4_layer0_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !lyr_err[c*N_LAYER]);

    // R8: a missing layer 0 never coexists with an overall flag
    a_r8_miss_blocks_ovr: assert property (@(posedge clk) disable iff (!rst_n)
      miss_err[c*N_LAYER] |-> !ovr_err[c]);
  end

  assign cur_d = {|miss_d, |lyr_d, |ovr_d};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sum_tag_q <= '0;
      ovr_err   <= '0;
      lyr_err   <= '0;
      miss_err  <= '0;
      cur_q     <= '0;
      sticky_q  <= '0;
      done_q    <= 1'b0;
    end else begin
      done_q <= finish;
      if (open_evt) begin
        sum_tag_q <= sum_tag;
        ovr_err   <= '0;
        lyr_err   <= '0;
        miss_err  <= '0;
        cur_q     <= '0;
      end else if (finish) begin
        ovr_err   <= ovr_d;
        lyr_err   <= lyr_d;
        miss_err  <= miss_d;
        cur_q     <= cur_d;
        sticky_q  <= sticky_q | cur_d;
      end
    end
  end

  assign done   = done_q;
  assign status = {sticky_q, cur_q};

  // R7: done lasts a single cycle
  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R2: opening an event wipes the per-event results
  a_r2_open_clears: assert property (@(posedge clk) disable iff (!rst_n)
    open_evt |=> (ovr_err == '0 && lyr_err == '0 && miss_err == '0 && status[2:0] == 3'b000));

  // R10: sticky summary bits never drop
  a_r10_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status[5:3] & $past(status[5:3])) == $past(status[5:3])));

  // R7: results hold between publication and the next event
  a_r7_results_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!open_evt && !finish) |=> $stable(ovr_err) && $stable(lyr_err) && $stable(miss_err));
endmodule

// File: tb/test_tag_phase_check.sv
module test_tag_phase_check;
  localparam int NC = 4;
  localparam int NL = 9;
  localparam int TW = 3;
  localparam int NS = NC * NL;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sum_valid = 1'b0;
  logic          sum_ready;
  logic [TW-1:0] sum_tag = '0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [1:0]    in_cable = '0;
  logic [3:0]    in_layer = '0;
  logic [TW-1:0] in_tag = '0;
  logic          eoe = 1'b0;
  logic          done;
  logic [NC-1:0] ovr_err;
  logic [NS-1:0] lyr_err;
  logic [NS-1:0] miss_err;
  logic [5:0]    status;

  int  checks = 0;
  int  errors = 0;
  bit  finished = 0;

  int  etag [NC][NL];
  bit  pres [NC][NL];
  int  cur_sum;
  logic [2:0] exp_sticky = 3'b000;

  always #5 clk = ~clk;

  tag_phase_check i_tag_phase_check (
    .clk(clk), .rst_n(rst_n),
    .sum_valid(sum_valid), .sum_ready(sum_ready), .sum_tag(sum_tag),
    .in_valid(in_valid), .in_ready(in_ready), .in_cable(in_cable),
    .in_layer(in_layer), .in_tag(in_tag), .eoe(eoe),
    .done(done), .ovr_err(ovr_err), .lyr_err(lyr_err),
    .miss_err(miss_err), .status(status)
  );

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic model_fill(int t);
    for (int c = 0; c < NC; c++)
      for (int l = 0; l < NL; l++) begin
        etag[c][l] = t;
        pres[c][l] = 1'b1;
      end
  endtask

  task automatic open_event(int t);
    sum_valid = 1'b1;
    sum_tag = TW'(t);
    cur_sum = t;
    @(negedge clk);
    sum_valid = 1'b0;
    chk("R2 sum_ready closed", 64'(sum_ready), 64'd0);
    chk("R2 in_ready open", 64'(in_ready), 64'd1);
    chk("R2 flags cleared", 64'({|ovr_err, |lyr_err, |miss_err, status[2:0]}), 64'd0);
    chk("R2 sticky kept", 64'(status[5:3]), 64'(exp_sticky));
  endtask

  task automatic beat(int c, int l, int t);
    in_valid = 1'b1;
    in_cable = 2'(c);
    in_layer = 4'(l);
    in_tag = TW'(t);
    @(negedge clk);
  endtask

  task automatic send_model(bit descending);
    for (int c = 0; c < NC; c++)
      for (int k = 0; k < NL; k++) begin
        int l;
        l = descending ? NL - 1 - k : k;
        if (pres[c][l]) beat(c, l, etag[c][l]);
      end
    in_valid = 1'b0;
  endtask

  task automatic compare(string req);
    logic [NC-1:0] eo;
    logic [NS-1:0] el, em;
    logic [2:0]    ec;
    eo = '0; el = '0; em = '0;
    for (int c = 0; c < NC; c++) begin
      eo[c] = pres[c][0] && (etag[c][0] != cur_sum);
      for (int l = 0; l < NL; l++) begin
        em[c*NL+l] = !pres[c][l];
        if (l > 0)
          el[c*NL+l] = pres[c][0] && pres[c][l] && (etag[c][l] != etag[c][0]);
      end
    end
    ec = {|em, |el, |eo};
    exp_sticky = exp_sticky | ec;
    chk({req, " ovr_err"}, 64'(ovr_err), 64'(eo));
    chk({req, " lyr_err"}, 64'(lyr_err), 64'(el));
    chk({req, " miss_err"}, 64'(miss_err), 64'(em));
    chk({req, " R10 status"}, 64'(status), 64'({exp_sticky, ec}));
  endtask

  // completion by all layers: done one cycle after the completing edge
  task automatic finish_full(string req);
    chk("R7 done not early", 64'(done), 64'd0);
    @(negedge clk);
    chk("R7 done pulse", 64'(done), 64'd1);
    compare(req);
    @(negedge clk);
    chk("R7 done single", 64'(done), 64'd0);
    chk("R2 back to idle", 64'({sum_ready, in_ready}), 64'b10);
  endtask

  task automatic finish_eoe(string req);
    eoe = 1'b1;
    #1;
    chk("R2 in_ready low under eoe", 64'(in_ready), 64'd0);
    @(negedge clk);
    eoe = 1'b0;
    chk("R8 done after eoe", 64'(done), 64'd1);
    compare(req);
    @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1 sum_ready", 64'(sum_ready), 64'd1);
    chk("R1 in_ready", 64'(in_ready), 64'd0);
    chk("R1 done", 64'(done), 64'd0);
    chk("R1 flags", 64'({|ovr_err, |lyr_err, |miss_err}), 64'd0);
    chk("R1 status", 64'(status), 64'd0);
  endtask

  task automatic t_clean;
    open_event(4);
    model_fill(4);
    send_model(1'b0);
    finish_full("R3 clean");
  endtask

  task automatic t_all_next;
    open_event(2);
    model_fill(2);
    for (int l = 0; l < NL; l++) etag[1][l] = 3;
    send_model(1'b1);
    finish_full("R5 all N+1");
  endtask

  task automatic t_split;
    open_event(5);
    model_fill(5);
    etag[2][0] = 4;
    for (int l = 1; l < NL; l++) etag[2][l] = 6;
    send_model(1'b0);
    finish_full("R6 N-1 then N+1");
  endtask

  task automatic t_single_layer;
    open_event(1);
    model_fill(1);
    etag[3][5] = 0;
    etag[0][0] = 2;
    send_model(1'b1);
    finish_full("R4 one layer");
  endtask

  task automatic t_wrap;
    open_event(7);
    model_fill(7);
    etag[0][0] = 0;
    for (int l = 1; l < NL; l++) etag[0][l] = 0;
    send_model(1'b0);
    finish_full("R3 no wrap slack");
  endtask

  task automatic t_missing;
    open_event(3);
    model_fill(3);
    pres[0][4] = 1'b0;
    pres[1][0] = 1'b0;
    for (int l = 1; l < NL; l++) etag[1][l] = 6;
    etag[2][7] = 1;
    send_model(1'b0);
    finish_eoe("R8 missing");
  endtask

  task automatic t_drop_overwrite;
    open_event(6);
    model_fill(6);
    beat(3, 5, 2);
    beat(0, 12, 1);
    beat(2, 9, 0);
    send_model(1'b0);
    finish_full("R9 drop and overwrite");
  endtask

  task automatic t_sticky_after_clean;
    open_event(0);
    model_fill(0);
    send_model(1'b1);
    finish_full("R10 clean after errors");
    chk("R10 sticky set", 64'(status[5:3]), 64'b111);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_clean();
    t_all_next();
    t_split();
    t_single_layer();
    t_wrap();
    t_missing();
    t_drop_overwrite();
    t_sticky_after_clean();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule